// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits on the controller side of a two-wire serial bus. It returns the bus to a known idle state after a transfer was cut short, after power was lost, or after a system reset. Such an event can leave a target device holding the data line low in the middle of a byte. When software or a higher-level controller raises a recovery request, the sequencer toggles the clock line through an open-drain output enable. It leaves the data line released, so the stuck target can shift out the rest of its byte and let go of the line.

The sequencer samples the synchronized data line at the end of every clock-high phase. As soon as the line reads high, it stops clocking and issues a start condition. The start takes four steps: SDA is pulled low while SCL is high, then SCL is pulled low, then SDA is released, then SCL is released. After the start it reports success with a one-cycle done pulse. The train of clocks is bounded. If the data line is still low when the last allowed clock has been checked, the sequencer raises a one-cycle fail pulse, issues no start, and leaves both lines released.

Both pad outputs are output enables: a 1 pulls the line low, and a 0 releases it to the pull-up. The length of each bus phase in system clocks is set by a parameter, and so is the depth of the input synchronizer.

Top module: `bus_recover`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, done and fail are all 0. Whenever busy is 0, scl_oe and sda_oe are both 0.
- R2: A recovery request (recover_req high for one clock) while idle sets busy and starts clock pulses, each made of a low phase (scl_oe=1) followed by a high phase (scl_oe=0). sda_oe stays 0 for every pulse.
- R3: Every clock low phase and every clock high phase between pulses lasts exactly PHASE_CYC system clocks. Every step of the start condition also lasts PHASE_CYC clocks.
- R4: SDA is sampled at the end of each clock-high phase, and at least one pulse is always issued. Clocking stops after the first pulse whose high phase sees SDA high. A target that releases SDA after holding it through N pulses therefore gets N+1 pulses.
- R5: No more than MAX_PULSES clock pulses (default 9) are issued in one recovery.
- R6: On success, a start condition follows the last pulse: sda_oe rises while scl_oe is 0, then scl_oe rises, then sda_oe falls while scl_oe is 1, then scl_oe falls. SDA is driven for exactly 2*PHASE_CYC clocks. A one-cycle done pulse comes with the release of SCL.
- R7: If SDA is still low at the end of pulse MAX_PULSES, a one-cycle fail pulse is raised, sda_oe is never asserted, and both lines are released.
- R8: busy is high for exactly pulses*2*PHASE_CYC clocks on failure and pulses*2*PHASE_CYC + 3*PHASE_CYC clocks on success. It falls in the cycle that done or fail rises. A request made while busy is ignored and starts no further recovery.
- R9: done and fail are never high together, and each recovery produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | Recovery request, sampled when idle |
| sda_in | input | 1 | Level of the SDA line as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | High while a recovery is in progress |
| done | output | 1 | One-cycle pulse: bus freed and start issued |
| fail | output | 1 | One-cycle pulse: SDA still low after the last pulse |

## Verification
A wrong pulse counter shows up at the pads within one clock pulse of the error: either an extra SCL rise past the limit, or a recovery that ends a pulse early against a target model that releases the line after a known number of pulses. A phase timer that is off by one appears in the measured length of the very next SCL low or high phase. It also changes the total busy length. A fault in the start ordering shows as SDA moving while SCL is high in the wrong direction, or as the wrong count of SDA-driven cycles, before done is seen. A stale busy or a request that is not ignored appears within the idle window after done or fail, as extra SCL edges or busy coming back.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_START_FALL,
      ST_START_HOLD,
      ST_START_REL
   } br_state_e;

endpackage

// File: rtl/br_phase_timer.sv
module br_phase_timer #(
   parameter int PHASE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

   logic [CW-1:0] cnt;

   // reloads at every phase boundary so each state lasts PHASE_CYC clocks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= LAST;
      else if (!run || cnt == '0)
         cnt <= LAST;
      else
         cnt <= cnt - CW'(1);
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/br_sda_sync.sv
module br_sda_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/br_seq_fsm.sv
module br_seq_fsm
   import bus_recover_pkg::*;
#(
   parameter int MAX_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic tick,
   input  logic sda_s,
   output logic run,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done,
   output logic fail
);
   localparam int PW = $clog2(MAX_PULSES + 1);
   localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

   br_state_e     state, nxt;
   logic [PW-1:0] pulses;
   logic          last_pulse;

   assign last_pulse = (pulses == LAST_PULSE);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:       if (req)  nxt = ST_LOW;
         ST_LOW:        if (tick) nxt = ST_HIGH;
         ST_HIGH:
            if (tick) begin
               if (sda_s)           nxt = ST_START_FALL;
               else if (last_pulse) nxt = ST_IDLE;
               else                 nxt = ST_LOW;
            end
         ST_START_FALL: if (tick) nxt = ST_START_HOLD;
         ST_START_HOLD: if (tick) nxt = ST_START_REL;
         ST_START_REL:  if (tick) nxt = ST_IDLE;
         default:                 nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pulses <= '0;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
         done   <= 1'b0;
         fail   <= 1'b0;
      end else begin
         state  <= nxt;
         if (state == ST_IDLE)
            pulses <= '0;
         else if (state == ST_HIGH && tick)
            pulses <= pulses + PW'(1);
         scl_oe <= (nxt == ST_LOW) || (nxt == ST_START_HOLD) || (nxt == ST_START_REL);
         sda_oe <= (nxt == ST_START_FALL) || (nxt == ST_START_HOLD);
         done   <= (state == ST_START_REL) && tick;
         fail   <= (state == ST_HIGH) && tick && !sda_s && last_pulse;
      end
   end

   assign run  = (state != ST_IDLE);
   assign busy = run;
endmodule

// File: rtl/bus_recover.sv
module bus_recover #(
   parameter int PHASE_CYC   = 8,
   parameter int MAX_PULSES  = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done,
   output logic fail
);
   generate
      if (PHASE_CYC < 2) begin : g_bad_phase
         $error("PHASE_CYC must be at least 2");
      end
      if (MAX_PULSES < 1 || MAX_PULSES > 255) begin : g_bad_pulses
         $error("MAX_PULSES must be in 1..255");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= PHASE_CYC) begin : g_bad_sync
         $error("SYNC_STAGES must be below PHASE_CYC");
      end
   endgenerate

   logic run, tick, sda_s;

   br_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   br_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   br_seq_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(recover_req), .tick(tick), .sda_s(sda_s),
      .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
      .done(done), .fail(fail)
   );
endmodule

// File: rtl/bus_recover_chk.sv
module bus_recover_chk #(
   parameter int MAX_PULSES = 9
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic scl_oe,
   input logic sda_oe,
   input logic done,
   input logic fail
);
   logic [7:0] rises;
   logic       scl_oe_d;
   logic       started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rises    <= '0;
         scl_oe_d <= 1'b0;
         started  <= 1'b0;
      end else begin
         scl_oe_d <= scl_oe;
         if (!busy) begin
            rises   <= '0;
            started <= 1'b0;
         end else begin
            if (scl_oe_d && !scl_oe) rises <= rises + 8'd1;
            if (sda_oe) started <= 1'b1;
         end
      end
   end

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   assert_pulse_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rises) <= MAX_PULSES);

   assert_start_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_oe);

   assert_fail_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !started);

   assert_end_of_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> ($past(busy) && !busy));

   assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
endmodule

bind bus_recover bus_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .scl_oe(scl_oe),
   .sda_oe(sda_oe), .done(done), .fail(fail)
);

// File: tb/tb_bus_recover.sv
module tb_bus_recover;
   localparam int P    = 4;
   localparam int MAXP = 9;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recover_req = 1'b0;
   logic scl_oe, sda_oe, busy, done, fail;
   logic slave_low = 1'b0;
   logic sda_in;

   assign sda_in = !sda_oe && !slave_low;

   always #2 clk = ~clk;

   bus_recover #(.PHASE_CYC(P), .MAX_PULSES(MAXP), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail)
   );

   int checks = 0, errors = 0, cyc = 0;
   int n_hold = 0, rise_seen = 0;
   int clocks, starts, badorder, badlen, sda_drv, busy_cyc, done_cnt, fail_cnt;
   int lowrun = 0, highrun = 0;
   bit lowhad = 0, prev_scl = 0, prev_sda = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_clocks(input int nh);
      return (nh + 1 < MAXP) ? nh + 1 : MAXP;
   endfunction

   function automatic bit exp_ok(input int nh);
      return nh < MAXP;
   endfunction

   // target model and port monitor, evaluated away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (prev_scl && !scl_oe) begin
         if (busy) clocks++;
         rise_seen++;
         if (!lowhad && lowrun != P) badlen++;
         lowrun = 0;
         lowhad = 0;
      end
      if (!prev_scl && scl_oe) begin
         if (highrun != 0 && highrun != P) badlen++;
         highrun = 0;
         if (rise_seen >= n_hold) slave_low = 1'b0;
      end
      if (scl_oe) begin
         lowrun++;
         if (sda_oe) lowhad = 1;
      end
      if (!busy) highrun = 0;
      else if (!scl_oe && !sda_oe) highrun++;
      if (!prev_sda && sda_oe) begin
         if (!scl_oe) starts++;
         else badorder++;
      end
      if (prev_sda && !sda_oe && !scl_oe) badorder++;
      if (sda_oe) sda_drv++;
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if (fail) fail_cnt++;
      prev_scl = scl_oe;
      prev_sda = sda_oe;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
         $finish;
      end
   end

   task automatic run_one(input int nh, input bit poke);
      int k;
      bit ok;
      int ec;
      ok = exp_ok(nh);
      ec = exp_clocks(nh);
      @(posedge clk);
      n_hold = nh;
      slave_low = (nh > 0);
      rise_seen = 0;
      clocks = 0; starts = 0; badorder = 0; badlen = 0;
      sda_drv = 0; busy_cyc = 0; done_cnt = 0; fail_cnt = 0;
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      recover_req = 1'b0;
      k = 0;
      while (!(done || fail) && k < 5000) begin
         @(negedge clk);
         k++;
         recover_req = (poke && (k == 5 || k == 6));
      end
      recover_req = 1'b0;
      chk(k < 5000, "R8 recovery ended", k, 0);
      repeat (3 * P + 4) @(negedge clk);
      chk(clocks == ec, "R4/R5 clock pulses", clocks, ec);
      chk(done_cnt == (ok ? 1 : 0), "R6 done pulses", done_cnt, ok ? 1 : 0);
      chk(fail_cnt == (ok ? 0 : 1), "R7 fail pulses", fail_cnt, ok ? 0 : 1);
      chk(starts == (ok ? 1 : 0), "R6 start conditions", starts, ok ? 1 : 0);
      chk(sda_drv == (ok ? 2 * P : 0), "R2/R7 sda driven cycles", sda_drv, ok ? 2 * P : 0);
      chk(badorder == 0, "R6 edge order violations", badorder, 0);
      chk(badlen == 0, "R3 phase length violations", badlen, 0);
      chk(busy_cyc == ec * 2 * P + (ok ? 3 * P : 0), "R8 busy cycles", busy_cyc,
          ec * 2 * P + (ok ? 3 * P : 0));
      chk(!scl_oe && !sda_oe && !busy, "R1 released after recovery",
          {scl_oe, sda_oe, busy}, 0);
      chk(done_cnt + fail_cnt == 1, "R9 one outcome", done_cnt + fail_cnt, 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk({scl_oe, sda_oe, busy, done, fail} == 5'b0, "R1 reset state",
          {scl_oe, sda_oe, busy, done, fail}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk({scl_oe, sda_oe, busy, done, fail} == 5'b0, "R1 idle after reset",
          {scl_oe, sda_oe, busy, done, fail}, 0);
      run_one(0, 1'b0);   // R4: SDA already free, single pulse
      run_one(1, 1'b0);   // R4: two pulses
      run_one(8, 1'b0);   // R5: release just in time, nine pulses
      run_one(9, 1'b0);   // R7: still low after the last pulse
      run_one(30, 1'b0);  // R7: permanently stuck line
      run_one(3, 1'b1);   // R8: request while busy is ignored
      run_one(12, 1'b1);  // R8: request while busy on the failing path
      for (int i = 0; i < 16; i++) begin
         run_one(int'($urandom_range(0, 11)), bit'($urandom_range(0, 1)));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end
endmodule